// File: doc/BRIEF.md
# Queued-Command I2C Master with Underflow Policy and Debug Freeze

This controller drives an I2C bus as master. A host writes a small queue, one entry per push. Each entry pairs an operation code with a byte, and the controller executes the entries in order. It generates START and repeated START conditions with an address byte, transmits data bytes, receives data bytes, and closes a transfer with STOP. The controller drives SCL and SDA as open-drain lines: an enable output high pulls its line low. SDA is read back from the bus.

All decisions are made at the byte boundary, after the acknowledge slot, while SCL is held low. If the queue is empty at that point, a configuration input sets the outcome. With auto-stop set, the controller ends the transfer with STOP. With auto-stop clear, it keeps SCL low and waits for the host to queue more entries. When the debug-freeze enable is set, a halt input stops the controller at the next byte boundary. The bus stays claimed for as long as the halt lasts, and the controller resumes when the halt is released. A NACK on any byte that the master transmits sets an error flag, flushes the queue and ends the transfer with STOP.

Top module: `i2c_fifo_master`

## Requirements
- R1: The queue holds 4 entries. Each entry is an operation code push_cmd (0 = transmit, 1 = receive, 2 = START plus address, 3 = STOP) and a byte push_data. When 4 entries are waiting, push_ready is low and a push is dropped. A dropped entry never reaches the bus.
- R2: An entry with code 2 sends START, or a repeated START if the bus is already claimed, and then sends push_data MSB first as the address byte. A write address, an index byte, a repeated START, a read address and a read byte are all sent with no STOP between them.
- R3: An entry with code 0 sends push_data MSB first and releases SDA during the acknowledge slot.
- R4: With cfg_autostop high, if the queue is empty at a byte boundary, the controller sends STOP, releases both lines and drops busy.
- R5: With cfg_autostop low, if the queue is empty at a byte boundary, the controller holds SCL low and keeps busy high. It continues with the next entry once one is pushed.
- R6: While no transfer is in progress, every entry except code 2 is discarded and nothing appears on the bus. After a STOP, data needs a new code-2 entry.
- R7: While cfg_dbg_en and dbg_halt are both high, the controller stops at the next byte boundary. It holds SCL low, keeps busy high, sends no STOP and sends no queued entry, even when auto-stop is set.
- R8: When dbg_halt falls, the controller sends the queued entries in order. With auto-stop set, it then sends STOP.
- R9: While cfg_dbg_en is low, dbg_halt has no effect, and an empty queue follows the auto-stop policy.
- R10: If SDA reads high in the acknowledge slot of a byte the master transmitted, nack_err is set, the remaining entries are flushed and STOP is sent. The next START clears nack_err.
- R11: An entry with code 1 releases SDA for 8 bits and samples them MSB first. In the acknowledge slot the master drives ACK, or NACK when push_data bit 0 is 1. rx_valid pulses with the byte on rx_data.
- R12: One SCL period inside a byte lasts 4*(clk_div+1) clock cycles. SDA changes only while SCL is low, except for the START and STOP edges.
- R13: After reset, busy, scl_oe, sda_oe and nack_err are low and push_ready is high. busy is high from the START until the STOP completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_autostop | input | 1 | Send STOP when the queue runs empty at a byte boundary |
| cfg_dbg_en | input | 1 | Lets dbg_halt freeze the controller |
| dbg_halt | input | 1 | Debug halt request |
| clk_div | input | DIVW | Quarter-bit length minus one, in clock cycles |
| push | input | 1 | Write one entry into the queue |
| push_cmd | input | 3 | Operation code of the entry |
| push_data | input | 8 | Byte of the entry |
| push_ready | output | 1 | Queue has room |
| sda_i | input | 1 | SDA level read from the bus |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| busy | output | 1 | Bus claimed by this master |
| nack_err | output | 1 | A transmitted byte was not acknowledged |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Last received byte |

## Verification
The bench includes an I2C target model that logs every START, STOP and byte seen on the wired bus. The tests compare that log against the expected sequence. Single writes with the bytes 00, FF, A5 and 5A check the bit order and confirm that no constant level is mistaken for data. A combined write, index, repeated START and read transfer shows that the bus stays claimed and that the read path works. Separate runs with the queue drained cover each setting of the auto-stop bit, each setting of the debug enable with halt raised, an address NACK with entries still queued, and pushes into a full queue during a freeze. Each run shows on the bus which policy the controller followed.

// File: rtl/i2c_fifo_master.sv
module i2c_fifo_master #(
  parameter int DEPTH = 4,
  parameter int DIVW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_autostop,
  input  logic            cfg_dbg_en,
  input  logic            dbg_halt,
  input  logic [DIVW-1:0] clk_div,
  input  logic            push,
  input  logic [2:0]      push_cmd,
  input  logic [7:0]      push_data,
  output logic            push_ready,
  input  logic            sda_i,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic            busy,
  output logic            nack_err,
  output logic            rx_valid,
  output logic [7:0]      rx_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [2:0] C_TX = 3'd0, C_RX = 3'd1, C_START = 3'd2, C_STOP = 3'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_WAIT, S_STOP} st_t;
  st_t state;

  logic [10:0]     mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt_q;
  logic [DIVW-1:0] dcnt;
  logic [1:0]      ph;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic            rd, nlast, rep, npend, samp;

  wire       empty  = (cnt_q == '0);
  wire [2:0] hcmd   = mem[rp][10:8];
  wire [7:0] hdat   = mem[rp][7:0];
  wire       frozen = cfg_dbg_en && dbg_halt;
  wire       timed  = (state == S_START) || (state == S_BIT) || (state == S_STOP);
  wire       tick   = timed && (dcnt == clk_div);
  wire       flush  = (state == S_WAIT) && npend;
  wire       pop    = !empty && ((state == S_IDLE) || (state == S_WAIT && !npend && !frozen));
  wire       wr     = push && push_ready && !flush;

  assign push_ready = (cnt_q != CW'(DEPTH));
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk) if (wr) mem[wp] <= {push_cmd, push_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt_q <= '0;
    end else if (flush) begin
      rp <= wp; cnt_q <= '0;
    end else begin
      if (wr)  wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt_q <= cnt_q + CW'(wr) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else if (!timed || tick) dcnt <= '0;
    else dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0; rd <= 1'b0; nlast <= 1'b0;
      rep <= 1'b0; npend <= 1'b0; samp <= 1'b0; nack_err <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (pop && hcmd == C_START) begin
            state <= S_START; rep <= 1'b0; sh <= hdat; nack_err <= 1'b0; ph <= '0;
          end
        S_START:
          if (tick) begin
            if (ph == 2'd3) begin
              state <= S_BIT; bitn <= '0; rd <= 1'b0; ph <= '0;
            end else ph <= ph + 1'b1;
          end
        S_BIT:
          if (tick) begin
            if (ph == 2'd2) begin
              samp <= sda_i;
              if (bitn == 4'd8) begin
                if (rd) begin rx_valid <= 1'b1; rx_data <= sh; end
                else if (sda_i) begin nack_err <= 1'b1; npend <= 1'b1; end
              end
            end
            if (ph == 2'd3) begin
              ph <= '0;
              if (bitn == 4'd8) state <= S_WAIT;
              else begin bitn <= bitn + 1'b1; sh <= {sh[6:0], samp}; end
            end else ph <= ph + 1'b1;
          end
        S_WAIT:
          if (npend) begin
            npend <= 1'b0; state <= S_STOP; ph <= '0;
          end else if (!frozen) begin
            if (!empty) begin
              case (hcmd)
                C_TX:    begin state <= S_BIT; sh <= hdat; rd <= 1'b0; bitn <= '0; ph <= '0; end
                C_RX:    begin state <= S_BIT; rd <= 1'b1; nlast <= hdat[0]; bitn <= '0; ph <= '0; end
                C_START: begin state <= S_START; rep <= 1'b1; sh <= hdat; nack_err <= 1'b0; ph <= '0; end
                C_STOP:  begin state <= S_STOP; ph <= '0; end
                default: ;
              endcase
            end else if (cfg_autostop) begin
              state <= S_STOP; ph <= '0;
            end
          end
        S_STOP:
          if (tick) begin
            if (ph == 2'd3) state <= S_IDLE;
            else ph <= ph + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (state)
      S_START: begin scl_oe = (ph == 2'd0 && rep) || ph == 2'd3; sda_oe = ph[1]; end
      S_BIT: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = (bitn == 4'd8) ? (rd && !nlast) : (!rd && !sh[7]);
      end
      S_WAIT:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
      S_STOP:  begin scl_oe = (ph == 2'd0); sda_oe = !ph[1]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_fifo_master_chk.sv
module i2c_fifo_master_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_autostop,
  input logic          cfg_dbg_en,
  input logic          dbg_halt,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          busy,
  input logic          rx_valid,
  input logic [2:0]    st,
  input logic [CW-1:0] cnt,
  input logic          npend
);
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R1
  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe)) |-> (st == 3'd1 || st == 3'd4)); // R12
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_oe && !sda_oe)); // R4
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && cfg_dbg_en && dbg_halt && !npend) |=> (st == 3'd3 && busy && scl_oe)); // R7
  AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && npend) |=> st == 3'd4); // R10
  AST_HALT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && !cfg_dbg_en && cfg_autostop && cnt == '0 && !npend) |=> st == 3'd4); // R9
  AST_RX_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> busy); // R11
endmodule

bind i2c_fifo_master i2c_fifo_master_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_autostop(cfg_autostop), .cfg_dbg_en(cfg_dbg_en),
  .dbg_halt(dbg_halt), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .rx_valid(rx_valid),
  .st(state), .cnt(cnt_q), .npend(npend)
);

// File: tb/i2c_fifo_master_bench.sv
`timescale 1ns/1ps
module i2c_fifo_master_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_autostop = 1'b1, cfg_dbg_en = 1'b0, dbg_halt = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic push = 1'b0;
  logic [2:0] push_cmd = '0;
  logic [7:0] push_data = '0;
  logic push_ready, scl_oe, sda_oe, busy, nack_err, rx_valid;
  logic [7:0] rx_data;
  logic s_low = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || s_low);

  always #10 clk = !clk;

  i2c_fifo_master u_i2c_fifo_master (
    .clk(clk), .rst_n(rst_n), .cfg_autostop(cfg_autostop), .cfg_dbg_en(cfg_dbg_en),
    .dbg_halt(dbg_halt), .clk_div(clk_div), .push(push), .push_cmd(push_cmd),
    .push_data(push_data), .push_ready(push_ready), .sda_i(sda), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(busy), .nack_err(nack_err), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  // target model: logs START=100h, STOP=200h, bytes as values
  int evlog [64];
  int nlog = 0;
  logic slave_ack = 1'b1;
  logic [7:0] rdv = 8'hC6;
  logic pscl = 1'b1, psda = 1'b1, s_addr = 1'b0, s_read = 1'b0, mnack = 1'b0;
  logic [7:0] ssh = '0;
  int bitc = 0;
  realtime t_prev = 0, t_last = 0;

  always @(scl or sda) begin
    if (scl && pscl && psda && !sda) begin
      if (nlog < 64) evlog[nlog] = 'h100;
      nlog++; bitc = 0; s_addr = 1'b1; s_read = 1'b0; s_low = 1'b0;
    end else if (scl && pscl && !psda && sda) begin
      if (nlog < 64) evlog[nlog] = 'h200;
      nlog++; bitc = 0; s_read = 1'b0; s_low = 1'b0;
    end else if (scl && !pscl) begin
      t_prev = t_last; t_last = $realtime;
      if (bitc < 8) begin
        ssh = {ssh[6:0], sda}; bitc++;
        if (bitc == 8) begin
          if (nlog < 64) evlog[nlog] = int'(ssh);
          nlog++;
        end
      end else if (bitc == 8) begin
        bitc = 9;
        if (s_read) mnack = sda;
      end
    end else if (!scl && pscl) begin
      if (bitc == 8) s_low = s_read ? 1'b0 : slave_ack;
      else if (bitc == 9) begin
        bitc = 0;
        if (s_addr) begin s_read = ssh[0]; s_addr = 1'b0; end
        else if (mnack) s_read = 1'b0;
        mnack = 1'b0;
        s_low = s_read && !rdv[7];
      end else if (s_read && bitc >= 1 && bitc < 8) s_low = !rdv[7 - bitc];
    end
    pscl = scl; psda = sda;
  end

  int ntests = 0, nfail = 0, base = 0;
  logic done = 1'b0;

  task automatic chk(input string r, input int got, input int exp);
    ntests++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  function automatic int ev(input int k);
    if (base + k < nlog && base + k < 64) return evlog[base + k];
    return -1;
  endfunction

  task automatic push_e(input logic [2:0] c, input logic [7:0] d);
    while (!push_ready) @(negedge clk);
    push_cmd = c; push_data = d; push = 1'b1;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic try_push(input logic [2:0] c, input logic [7:0] d);
    push_cmd = c; push_data = d; push = 1'b1;
    @(negedge clk);
    push = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_log(input int n);
    while (nlog - base < n) @(negedge clk);
  endtask

  localparam logic [15:0] VEC [4] = '{16'h5000, 16'h52FF, 16'hA4A5, 16'h1E5A};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 busy after reset", busy, 0);
    chk("R13 scl_oe after reset", scl_oe, 0);
    chk("R13 sda_oe after reset", sda_oe, 0);
    chk("R13 push_ready after reset", push_ready, 1);
    chk("R13 nack_err after reset", nack_err, 0);

    for (int i = 0; i < 4; i++) begin
      base = nlog;
      push_e(3'd2, VEC[i][15:8]);
      push_e(3'd0, VEC[i][7:0]);
      wait_idle();
      chk("R2 start", ev(0), 'h100);
      chk("R2 address", ev(1), int'(VEC[i][15:8]));
      chk("R3 data byte", ev(2), int'(VEC[i][7:0]));
      chk("R4 autostop", ev(3), 'h200);
      chk("R4 busy low", busy, 0);
    end

    base = nlog;
    push_e(3'd0, 8'h77);
    repeat (200) @(negedge clk);
    chk("R6 data after stop not sent", nlog - base, 0);
    chk("R6 still idle", busy, 0);

    base = nlog;
    push_e(3'd2, 8'h3A); push_e(3'd0, 8'h09); push_e(3'd2, 8'h3B);
    push_e(3'd1, 8'h01); push_e(3'd3, 8'h00);
    wait_idle();
    chk("R2 combined start", ev(0), 'h100);
    chk("R2 combined addr", ev(1), 'h3A);
    chk("R2 combined index", ev(2), 'h09);
    chk("R2 repeated start, no stop", ev(3), 'h100);
    chk("R2 read addr", ev(4), 'h3B);
    chk("R11 read byte on bus", ev(5), 'hC6);
    chk("R2 final stop", ev(6), 'h200);
    chk("R11 rx_data", rx_data, 'hC6);

    cfg_autostop = 1'b0; clk_div = 8'd2;
    base = nlog;
    push_e(3'd2, 8'h30); push_e(3'd0, 8'h81);
    wait_log(3);
    repeat (150) @(negedge clk);
    chk("R5 hold busy", busy, 1);
    chk("R5 hold scl low", scl_oe, 1);
    chk("R5 no stop while held", nlog - base, 3);
    chk("R12 scl period cycles", int'((t_last - t_prev) / 20.0), 12);
    push_e(3'd0, 8'h7E); push_e(3'd3, 8'h00);
    wait_idle();
    chk("R5 resumed byte", ev(3), 'h7E);
    chk("R5 stop after resume", ev(4), 'h200);

    cfg_autostop = 1'b1; clk_div = 8'd1; cfg_dbg_en = 1'b1;
    base = nlog;
    push_e(3'd2, 8'h20);
    @(negedge clk);
    dbg_halt = 1'b1;
    push_e(3'd0, 8'h01); push_e(3'd0, 8'h02); push_e(3'd0, 8'h03); push_e(3'd0, 8'h04);
    chk("R1 push_ready low when full", push_ready, 0);
    try_push(3'd0, 8'h05);
    wait_log(2);
    repeat (200) @(negedge clk);
    chk("R7 frozen busy", busy, 1);
    chk("R7 no stop, no queued byte", nlog - base, 2);
    dbg_halt = 1'b0;
    wait_idle();
    chk("R8 resume byte 1", ev(2), 'h01);
    chk("R8 resume byte 4", ev(5), 'h04);
    chk("R1 refused push absent", ev(6), 'h200);
    chk("R8 idle after stop", busy, 0);

    cfg_dbg_en = 1'b0; dbg_halt = 1'b1;
    base = nlog;
    push_e(3'd2, 8'h62);
    wait_idle();
    chk("R9 halt ignored addr", ev(1), 'h62);
    chk("R9 autostop applies", ev(2), 'h200);
    chk("R9 idle", busy, 0);
    dbg_halt = 1'b0;

    slave_ack = 1'b0;
    base = nlog;
    push_e(3'd2, 8'h44); push_e(3'd0, 8'h11); push_e(3'd2, 8'h46);
    wait_idle();
    repeat (200) @(negedge clk);
    chk("R10 nack_err set", nack_err, 1);
    chk("R10 stop after nack", ev(2), 'h200);
    chk("R10 queue flushed", nlog - base, 3);
    slave_ack = 1'b1;
    base = nlog;
    push_e(3'd2, 8'h50); push_e(3'd0, 8'h22);
    wait_idle();
    chk("R10 nack_err cleared by start", nack_err, 0);
    chk("R10 next transfer data", ev(2), 'h22);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      ntests++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end
endmodule